// File: doc/BRIEF.md
# Erase Range Walker

This block turns one erase request, given as a byte start address and a byte length, into a series of single-block erase commands. The memory it serves has two erase regions. The low region has small blocks and the high region, which begins where the low one ends, has large blocks. The block first decides whether the request is legal. A legal request is walked from low to high addresses, one block at a time. The step size is chosen from the region that holds the current address.

Each block command goes to a downstream command sequencer over a valid/ready handshake. The block then waits for a done pulse from the sequencer, which carries an error flag. When the walk ends, the block returns one response that gives success, an illegal request, or the address of the first block whose erase failed.

Top module: `erase_walker`

## Requirements
- R1: Region 0 covers bytes [0, R0_CNT·2^R0_LOG2) in blocks of 2^R0_LOG2 bytes. Region 1 follows directly, with R1_CNT blocks of 2^R1_LOG2 bytes. The device ends where region 1 ends. With the default parameters this gives 8×16 KiB, then 31×128 KiB, ending at 4 MiB.
- R2: A request whose start address is at or beyond the device end is answered with rsp_code 1 (illegal), and no erase command is issued.
- R3: A request whose start address is not a multiple of the block size of the region holding that address is answered with rsp_code 1, and no erase command is issued.
- R4: The end address is start+length, computed without overflow. A request is answered with rsp_code 1, with no erase command, when the end address is beyond the device end or is not a multiple of the block size of the region holding the end address. An end equal to the region 1 base counts as lying in region 1.
- R5: A legal request of length zero is answered with rsp_code 0 (success), and no erase command is issued.
- R6: A legal request issues exactly one command for each block in [start, end), in ascending order. Each step equals the block size of the region holding the current address, so the step widens when the walk crosses into region 1.
- R7: erase_addr stays stable while erase_valid is high and erase_ready is low. After a command is accepted, no new command is offered until erase_done has arrived.
- R8: When erase_done arrives with erase_err high, the walk stops at once. rsp_code is 2 and rsp_addr holds that block's address. No further command is issued.
- R9: When the last block completes without error, the block answers with rsp_code 0.
- R10: rsp_valid is a one-cycle pulse. req_ready is high only while the block is idle, so no request is accepted while a walk or a response is in progress.
- R11: After reset, req_ready is 1 and erase_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block idle; request taken on the same edge |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| erase_valid | output | 1 | Block erase command offered |
| erase_ready | input | 1 | Sequencer accepts the command |
| erase_addr | output | ADDR_W | Base address of the block to erase |
| erase_done | input | 1 | Sequencer finished the accepted command |
| erase_err | input | 1 | Erase failed; qualified by erase_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 success, 1 illegal request, 2 erase failure |
| rsp_addr | output | ADDR_W | Failing block address when rsp_code is 2 |

## Verification
The bench builds the block with 8-bit addresses. Region 0 has four 4-byte blocks and region 1 has three 16-byte blocks, so the device ends at byte 64. At this size every start from 0 to 71 can be combined with every length from 0 to 79, which covers misaligned starts and ends in both regions, ends exactly on the region boundary, and starts and ends past the device. Lengths near the top of the 8-bit range exercise overflow of the end-address sum. Failure injection at every block position of spanning walks checks that the walk stops early.

// File: rtl/erase_walker.sv
module erase_walker #(
  parameter int ADDR_W  = 32,
  parameter int R0_LOG2 = 14,
  parameter int R0_CNT  = 8,
  parameter int R1_LOG2 = 17,
  parameter int R1_CNT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              erase_valid,
  input  logic              erase_ready,
  output logic [ADDR_W-1:0] erase_addr,
  input  logic              erase_done,
  input  logic              erase_err,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int XW = ADDR_W + 1;
  localparam logic [XW-1:0] ONE     = {{ADDR_W{1'b0}}, 1'b1};
  localparam logic [XW-1:0] R0_BLK  = ONE << R0_LOG2;
  localparam logic [XW-1:0] R1_BLK  = ONE << R1_LOG2;
  localparam logic [XW-1:0] R1_BASE = R0_BLK * XW'(R0_CNT);
  localparam logic [XW-1:0] DEV_END = R1_BASE + R1_BLK * XW'(R1_CNT);
  localparam logic [1:0] C_OK = 2'd0, C_ILL = 2'd1, C_FAIL = 2'd2;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, RESP} st_t;
  st_t st;
  logic [XW-1:0] cur, fin;
  logic [1:0]    code_q;

  wire [XW-1:0] s_x  = {1'b0, req_addr};
  wire [XW-1:0] e_x  = {1'b0, req_addr} + {1'b0, req_len};
  wire [XW-1:0] s_m  = (s_x < R1_BASE) ? R0_BLK - ONE : R1_BLK - ONE;
  wire [XW-1:0] e_m  = (e_x < R1_BASE) ? R0_BLK - ONE : R1_BLK - ONE;
  wire bad = (s_x >= DEV_END) || ((s_x & s_m) != '0) ||
             (e_x > DEV_END)  || ((e_x & e_m) != '0);
  wire [XW-1:0] nxt = cur + ((cur < R1_BASE) ? R0_BLK : R1_BLK);

  assign req_ready   = (st == IDLE);
  assign erase_valid = (st == ISSUE);
  assign rsp_valid   = (st == RESP);
  assign erase_addr  = cur[ADDR_W-1:0];
  assign rsp_addr    = cur[ADDR_W-1:0];
  assign rsp_code    = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cur    <= '0;
      fin    <= '0;
      code_q <= C_OK;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          cur <= s_x;
          fin <= e_x;
          if (bad) begin
            code_q <= C_ILL;
            st     <= RESP;
          end else if (req_len == '0) begin
            code_q <= C_OK;
            st     <= RESP;
          end else begin
            st <= ISSUE;
          end
        end
        ISSUE: if (erase_ready) st <= WAIT;
        WAIT: if (erase_done) begin
          if (erase_err) begin
            code_q <= C_FAIL;
            st     <= RESP;
          end else if (nxt >= fin) begin
            code_q <= C_OK;
            st     <= RESP;
          end else begin
            cur <= nxt;
            st  <= ISSUE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module erase_walker_chk #(
  parameter int ADDR_W  = 32,
  parameter int R0_LOG2 = 14,
  parameter int R0_CNT  = 8,
  parameter int R1_LOG2 = 17,
  parameter int R1_CNT  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              erase_valid,
  input logic              erase_ready,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              rsp_valid
);
  localparam int XW = ADDR_W + 1;
  localparam logic [XW-1:0] ONE     = {{ADDR_W{1'b0}}, 1'b1};
  localparam logic [XW-1:0] R0_BLK  = ONE << R0_LOG2;
  localparam logic [XW-1:0] R1_BLK  = ONE << R1_LOG2;
  localparam logic [XW-1:0] R1_BASE = R0_BLK * XW'(R0_CNT);
  localparam logic [XW-1:0] DEV_END = R1_BASE + R1_BLK * XW'(R1_CNT);

  wire [XW-1:0] a_x = {1'b0, erase_addr};
  wire [XW-1:0] a_m = (a_x < R1_BASE) ? R0_BLK - ONE : R1_BLK - ONE;

  logic              seen;
  logic [ADDR_W-1:0] last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last <= '0;
    end else if (req_valid && req_ready) begin
      seen <= 1'b0;
    end else if (erase_valid && erase_ready) begin
      seen <= 1'b1;
      last <= erase_addr;
    end
  end

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && !erase_ready |=> erase_valid && $stable(erase_addr));
  // R7
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && erase_ready |=> !erase_valid);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_valid || rsp_valid) |-> !req_ready);
  // R6
  blk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid |-> ((a_x & a_m) == '0) && (a_x < DEV_END));
  // R6
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_valid && erase_ready && seen |-> erase_addr > last);
endmodule

bind erase_walker erase_walker_chk #(
  .ADDR_W(ADDR_W), .R0_LOG2(R0_LOG2), .R0_CNT(R0_CNT),
  .R1_LOG2(R1_LOG2), .R1_CNT(R1_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .erase_valid(erase_valid), .erase_ready(erase_ready),
  .erase_addr(erase_addr), .rsp_valid(rsp_valid)
);

// File: tb/erase_walker_bench.sv
module erase_walker_bench;
  localparam int AW = 8;
  localparam int B0 = 4, N0 = 4, B1 = 16, N1 = 3;
  localparam int BASE1 = B0 * N0;
  localparam int DEND  = BASE1 + B1 * N1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, erase_ready = 1'b0, erase_done = 1'b0, erase_err = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic req_ready, erase_valid, rsp_valid;
  logic [AW-1:0] erase_addr, rsp_addr;
  logic [1:0] rsp_code;

  int total = 0, bad = 0;
  int nlog = 0, fail_at = -1, gap = 0;
  int logv [16];
  bit finished = 0;

  always #5 clk = ~clk;

  erase_walker #(.ADDR_W(AW), .R0_LOG2(2), .R0_CNT(N0), .R1_LOG2(4), .R1_CNT(N1))
    u_erase_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .erase_valid(erase_valid),
      .erase_ready(erase_ready), .erase_addr(erase_addr), .erase_done(erase_done),
      .erase_err(erase_err), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_addr(rsp_addr));

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int blk(int a);
    return (a < BASE1) ? B0 : B1;
  endfunction

  // sequencer model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && erase_valid) begin
        int first;
        first = int'(erase_addr);
        repeat (gap % 3) @(negedge clk);
        chk(erase_valid && int'(erase_addr) == first, "R7 hold", int'(erase_addr), first);
        erase_ready = 1'b1;
        if (nlog < 16) logv[nlog] = int'(erase_addr);
        nlog++;
        @(negedge clk);
        erase_ready = 1'b0;
        repeat (gap % 4) begin
          @(negedge clk);
          chk(!erase_valid, "R7 outstanding", int'(erase_valid), 0);
        end
        erase_done = 1'b1;
        erase_err  = (nlog - 1 == fail_at);
        @(negedge clk);
        erase_done = 1'b0;
        erase_err  = 1'b0;
        gap++;
      end
    end
  end

  task automatic run(int s, int l, int fidx);
    int exp_a [16];
    int ne = 0, e, a, code_e, t = 0;
    bit legal;
    string tag;
    e = s + l;
    legal = !(s >= DEND || (s % blk(s)) != 0 || e > DEND || (e % blk(e)) != 0);
    a = s;
    if (legal) while (a < e) begin exp_a[ne] = a; ne++; a += blk(a); end
    if (!legal) begin
      code_e = 1;
      tag = (s >= DEND) ? "R2" : ((s % blk(s)) != 0) ? "R3" : "R4";
    end else if (fidx >= 0 && fidx < ne) begin
      code_e = 2; ne = fidx + 1; tag = "R8";
    end else begin
      code_e = 0; tag = (l == 0) ? "R5" : "R9";
    end
    nlog = 0; fail_at = fidx;
    @(negedge clk);
    req_addr = AW'(s); req_len = AW'(l); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && t < 400) begin @(negedge clk); t++; end
    chk(rsp_valid, "R10 response", int'(rsp_valid), 1);
    chk(rsp_code == 2'(code_e), tag, int'(rsp_code), code_e);
    chk(nlog == ne, "R6 block count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++)
      chk(logv[i] == exp_a[i], "R6 block addr", logv[i], exp_a[i]);
    if (code_e == 2) chk(int'(rsp_addr) == exp_a[fidx], "R8 fail addr", int'(rsp_addr), exp_a[fidx]);
    @(negedge clk);
    chk(!rsp_valid && req_ready && !erase_valid, "R10 pulse",
        int'({rsp_valid, req_ready, erase_valid}), 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !erase_valid && !rsp_valid, "R11 in reset",
        int'({req_ready, erase_valid, rsp_valid}), 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !erase_valid && !rsp_valid, "R11 after reset",
        int'({req_ready, erase_valid, rsp_valid}), 3'b100);
    // R1 R2 R3 R4 R5 R6 R9: full sweep over the small geometry
    for (int s = 0; s < 72; s++)
      for (int l = 0; l < 80; l++)
        run(s, l, -1);
    // R4: end-address sum past the 8-bit range
    run(40, 250, -1);
    run(0, 255, -1);
    run(255, 255, -1);
    // R8: failure at every position of spanning walks
    for (int f = 0; f < 7; f++) run(0, 64, f);
    for (int f = 0; f < 3; f++) run(12, 20, f);
    for (int f = 0; f < 2; f++) run(16, 32, f);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule